// File: doc/BRIEF.md
# Radix-4 Booth Floating-Point Multiplier

This block multiplies two single-precision (binary32) operands and returns a single-precision product. A one-cycle `start` pulse captures both operands. The block then forms the 48-bit product of the two 24-bit significands, with the hidden bit restored. It walks through the radix-4 Booth digits of the second significand and adds one signed partial product per cycle into an accumulator. The accumulator is a Kogge-Stone parallel-prefix adder.

Once every digit has been added, the block normalises the product, rounds it to nearest-even and sorts out the special operand classes. It then presents the packed result with a one-cycle `done` pulse, together with overflow, underflow and invalid flags. For observation it also exposes the raw significand product and the exponent sum less the bias.

Subnormal inputs are treated as zero. All outputs hold their values until the next `done`.

Top module: `fp_booth_mul`

## Requirements
- R1: `done` rises for exactly one cycle, 14 clock edges after the edge that samples `start` high. The result, the flags, `sig_prod` and `exp_sum` change only together with `done`.
- R2: A `start` pulse that arrives while an operation is in flight is ignored. Only the first operation completes, and it produces one `done` pulse.
- R3: `sig_prod` equals the integer product of the two 24-bit significands. Each significand is `{1, fraction}` when its exponent field (bits 30:23) is non-zero, and 0 otherwise.
- R4: `exp_sum` equals the sum of the two 8-bit exponent fields minus 127, as a 10-bit two's-complement value.
- R5: For finite, non-zero operands that produce a result in range, the result is the product rounded to nearest, ties to even. A rounding carry out of the fraction increments the exponent. No flag is set.
- R6: The sign bit (bit 31) of every non-NaN result is the XOR of the operand sign bits.
- R7: Zero times infinity, in either order, gives the quiet NaN 0x7FC00000 with `inv_flag` set.
- R8: Any NaN operand (exponent all ones, fraction non-zero) gives 0x7FC00000 with no flag set.
- R9: A zero or subnormal operand (exponent field 0), with no infinity or NaN involved, gives a signed zero with no flag set.
- R10: Infinity times a non-zero, non-NaN operand gives a signed infinity (exponent 0xFF, fraction 0) with no flag set.
- R11: When the rounded exponent exceeds 254, the result is a signed infinity and `ovf_flag` is set. At most one of the three flags is set at a time.
- R12: When the rounded exponent is below 1, the result is a signed zero and `unf_flag` is set.
- R13: After reset, `done`, `result`, the flags, `sig_prod` and `exp_sum` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; samples both operands |
| op_a | input | 32 | Multiplicand, binary32 |
| op_b | input | 32 | Multiplier, binary32 |
| result | output | 32 | Packed binary32 product |
| done | output | 1 | One-cycle completion pulse |
| ovf_flag | output | 1 | Overflow to infinity |
| unf_flag | output | 1 | Underflow to zero |
| inv_flag | output | 1 | Invalid operation (zero times infinity) |
| sig_prod | output | 48 | Raw significand product |
| exp_sum | output | 10 | Sum of exponent fields minus bias |

## Verification
Every output of an operation is due at one fixed point: 14 rising edges after the edge that samples `start`. One edge captures the operands, the next 13 each add one Booth partial product, and the final edge rounds and registers the result. The bench drives operands at a falling edge and then counts falling edges until `done` appears. It checks that the count is exactly 14, and at that same falling edge it compares the result, flags, `sig_prod` and `exp_sum` with the expected values. For the ignored-`start` case, the bench pulses `start` again five cycles into an operation. It then counts `done` pulses over the following 40 cycles and expects exactly one.

// File: rtl/fp_booth_mul.sv
module fp_booth_mul #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [EW+FW:0]     op_a,
  input  logic [EW+FW:0]     op_b,
  output logic [EW+FW:0]     result,
  output logic               done,
  output logic               ovf_flag,
  output logic               unf_flag,
  output logic               inv_flag,
  output logic [2*FW+1:0]    sig_prod,
  output logic [EW+1:0]      exp_sum
);
  localparam int DW    = EW + FW + 1;
  localparam int MW    = FW + 1;
  localparam int PW    = 2 * MW;
  localparam int NPP   = (MW + 2) / 2;
  localparam int YW    = 2 * NPP + 1;
  localparam int XW    = MW + 3;
  localparam int AW    = PW + 2;
  localparam int LG    = $clog2(AW);
  localparam int CW    = $clog2(NPP + 1);
  localparam int EXW   = EW + 2;
  localparam int BIAS  = 2 ** (EW - 1) - 1;
  localparam int EMAXN = 2 ** EW - 2;
  localparam logic [DW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  typedef enum logic [2:0] {K_NORM, K_ZERO, K_INF, K_NAN, K_INV} kind_t;

  st_t                     st;
  kind_t                   kind;
  logic [CW-1:0]           cnt;
  logic [MW-1:0]           mx;
  logic [YW-1:0]           yx;
  logic [AW-1:0]           acc;
  logic [EXW-1:0]          es;
  logic                    sgn;

  function automatic logic [AW-1:0] ks_add(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW-1:0] g, p, h;
    h = x ^ y;
    g = x & y;
    p = h;
    for (int s = 0; s < LG; s++) begin
      for (int i = AW - 1; i >= (1 << s); i--) begin
        g[i] = g[i] | (p[i] & g[i - (1 << s)]);
        p[i] = p[i] & p[i - (1 << s)];
      end
    end
    return h ^ {g[AW-2:0], 1'b0};
  endfunction

  // operand classification
  logic [EW-1:0] ea, eb;
  logic [FW-1:0] fa, fb;
  logic a_z, b_z, a_i, b_i, a_n, b_n;
  kind_t kind_in;

  assign ea  = op_a[DW-2:FW];
  assign eb  = op_b[DW-2:FW];
  assign fa  = op_a[FW-1:0];
  assign fb  = op_b[FW-1:0];
  assign a_z = (ea == '0);
  assign b_z = (eb == '0);
  assign a_i = (&ea) && (fa == '0);
  assign b_i = (&eb) && (fb == '0);
  assign a_n = (&ea) && (fa != '0);
  assign b_n = (&eb) && (fb != '0);

  always_comb begin
    if (a_n || b_n)                       kind_in = K_NAN;
    else if ((a_z && b_i) || (a_i && b_z)) kind_in = K_INV;
    else if (a_i || b_i)                  kind_in = K_INF;
    else if (a_z || b_z)                  kind_in = K_ZERO;
    else                                  kind_in = K_NORM;
  end

  // radix-4 Booth partial product for the current digit
  logic [2:0]    trio;
  logic [XW-1:0] xs, pp;
  logic [AW-1:0] ppe, acc_nx;

  assign trio = yx[2*cnt +: 3];
  assign xs   = {3'b000, mx};

  always_comb begin
    case (trio)
      3'b001, 3'b010: pp = xs;
      3'b011:         pp = xs << 1;
      3'b100:         pp = -(xs << 1);
      3'b101, 3'b110: pp = -xs;
      default:        pp = '0;
    endcase
  end

  assign ppe    = {{(AW-XW){pp[XW-1]}}, pp} << (2*cnt);
  assign acc_nx = ks_add(acc, ppe);

  // normalise and round
  logic [PW-1:0]         prod;
  logic                  hi, grd, stk, rup;
  logic [FW-1:0]         fr_n;
  logic [FW:0]           fr_r;
  logic signed [EXW-1:0] e_n;
  logic                  ovf_c, unf_c;

  assign prod = acc[PW-1:0];
  assign hi   = prod[PW-1];
  assign fr_n = hi ? prod[PW-2 -: FW] : prod[PW-3 -: FW];
  assign grd  = hi ? prod[PW-2-FW] : prod[PW-3-FW];
  assign stk  = hi ? (|prod[PW-3-FW:0]) : (|prod[PW-4-FW:0]);
  assign rup  = grd & (stk | fr_n[0]);
  assign fr_r = {1'b0, fr_n} + (FW+1)'(rup);
  assign e_n  = es + EXW'(hi) + EXW'(fr_r[FW]);
  assign ovf_c = e_n > $signed(EXW'(EMAXN));
  assign unf_c = e_n < $signed(EXW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_NORM;
      cnt      <= '0;
      mx       <= '0;
      yx       <= '0;
      acc      <= '0;
      es       <= '0;
      sgn      <= 1'b0;
      result   <= '0;
      done     <= 1'b0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      inv_flag <= 1'b0;
      sig_prod <= '0;
      exp_sum  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_RUN;
          kind <= kind_in;
          cnt  <= '0;
          acc  <= '0;
          mx   <= a_z ? '0 : {1'b1, fa};
          yx   <= {{(YW-MW-1){1'b0}}, (b_z ? {MW{1'b0}} : {1'b1, fb}), 1'b0};
          es   <= {2'b00, ea} + {2'b00, eb} - EXW'(BIAS);
          sgn  <= op_a[DW-1] ^ op_b[DW-1];
        end
        S_RUN: begin
          acc <= acc_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NPP - 1)) st <= S_FIN;
        end
        S_FIN: begin
          st       <= S_IDLE;
          done     <= 1'b1;
          sig_prod <= prod;
          exp_sum  <= es;
          ovf_flag <= 1'b0;
          unf_flag <= 1'b0;
          inv_flag <= 1'b0;
          case (kind)
            K_NAN:  result <= QNAN;
            K_INV:  begin result <= QNAN; inv_flag <= 1'b1; end
            K_INF:  result <= {sgn, {EW{1'b1}}, {FW{1'b0}}};
            K_ZERO: result <= {sgn, {(DW-1){1'b0}}};
            default: begin
              if (ovf_c) begin
                result   <= {sgn, {EW{1'b1}}, {FW{1'b0}}};
                ovf_flag <= 1'b1;
              end else if (unf_c) begin
                result   <= {sgn, {(DW-1){1'b0}}};
                unf_flag <= 1'b1;
              end else begin
                result <= {sgn, e_n[EW-1:0], fr_r[FW-1:0]};
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == S_FIN));
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |=> $stable(mx) && $stable(yx));
  a_r7_inv_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inv_flag) |-> (result == QNAN));
  a_r11_ovf_gives_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf_flag) |-> (result[DW-2:0] == {{EW{1'b1}}, {FW{1'b0}}}));
  a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_flag, unf_flag, inv_flag}));
  a_r12_unf_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf_flag) |-> (result[DW-2:0] == '0));
endmodule

// File: tb/sim_fp_booth_mul.sv
module sim_fp_booth_mul;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] result;
  logic        done, ovf_flag, unf_flag, inv_flag;
  logic [47:0] sig_prod;
  logic [9:0]  exp_sum;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_booth_mul u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .result(result), .done(done), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .inv_flag(inv_flag), .sig_prod(sig_prod), .exp_sum(exp_sum)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ref_mul(input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output logic [2:0] fl,
                         output logic [47:0] sp, output logic [9:0] es,
                         output string tag);
    logic [7:0]  ex, ey;
    logic [22:0] fx, fy;
    longint mxv, myv, p, q, rem, half;
    int e, sh;
    logic s;
    ex = x[30:23]; ey = y[30:23]; fx = x[22:0]; fy = y[22:0];
    s = x[31] ^ y[31];
    mxv = (ex == 0) ? 0 : longint'({1'b1, fx});
    myv = (ey == 0) ? 0 : longint'({1'b1, fy});
    p = mxv * myv;
    sp = p[47:0];
    es = 10'(int'(ex) + int'(ey) - 127);
    fl = 3'b000;
    if ((ex == 8'hFF && fx != 0) || (ey == 8'hFF && fy != 0)) begin
      r = 32'h7FC00000; tag = "R8";
    end else if ((ex == 0 && ey == 8'hFF) || (ex == 8'hFF && ey == 0)) begin
      r = 32'h7FC00000; fl = 3'b001; tag = "R7";
    end else if (ex == 8'hFF || ey == 8'hFF) begin
      r = {s, 8'hFF, 23'd0}; tag = "R10";
    end else if (ex == 0 || ey == 0) begin
      r = {s, 31'd0}; tag = "R9";
    end else begin
      sh = p[47] ? 24 : 23;
      q = p >> sh;
      rem = p & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      e = int'(ex) + int'(ey) - 127 + (sh - 23);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
      if (e > 254) begin
        r = {s, 8'hFF, 23'd0}; fl = 3'b100; tag = "R11";
      end else if (e < 1) begin
        r = {s, 31'd0}; fl = 3'b010; tag = "R12";
      end else begin
        r = {s, 8'(e), q[22:0]}; tag = "R5";
      end
    end
  endtask

  task automatic do_op(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er; logic [2:0] ef; logic [47:0] esp; logic [9:0] ees;
    string tag;
    int n;
    ref_mul(x, y, er, ef, esp, ees, tag);
    @(negedge clk);
    op_a = x; op_b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(n == LAT, "R1", "latency", 64'(n), 64'(LAT));
    chk(result == er, tag, "result", 64'(result), 64'(er));
    chk({ovf_flag, unf_flag, inv_flag} == ef, tag, "flags",
        64'({ovf_flag, unf_flag, inv_flag}), 64'(ef));
    chk(sig_prod == esp, "R3", "sig_prod", 64'(sig_prod), 64'(esp));
    chk(exp_sum == ees, "R4", "exp_sum", 64'(exp_sum), 64'(ees));
    if (er[30:23] != 8'hFF || er[22:0] == 0)
      chk(result[31] == (x[31] ^ y[31]), "R6", "sign", 64'(result[31]), 64'(x[31] ^ y[31]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    int nd;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(done == 0 && result == 0 && sig_prod == 0 && exp_sum == 0 &&
        {ovf_flag, unf_flag, inv_flag} == 0, "R13", "reset state",
        64'(result), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(32'h3F800000, 32'h3F800000);  // R5 1*1
    chk(result == 32'h3F800000, "R5", "1.0*1.0", 64'(result), 64'h3F800000);
    do_op(32'h3FC00000, 32'h3FC00000);  // R5 1.5*1.5
    chk(result == 32'h40100000, "R5", "1.5*1.5", 64'(result), 64'h40100000);
    do_op(32'hC0000000, 32'h40400000);  // R6 -2*3
    chk(result == 32'hC0C00000, "R6", "-2*3", 64'(result), 64'hC0C00000);
    do_op(32'h3F800001, 32'h3FC00000);  // R5 tie rounds up to even
    chk(result == 32'h3FC00002, "R5", "tie", 64'(result), 64'h3FC00002);
    do_op(32'h3FFFFFFF, 32'h3FFFFFFF);  // R5 near carry
    do_op(32'h7F000000, 32'h7F000000);  // R11
    chk(ovf_flag && result == 32'h7F800000, "R11", "overflow", 64'(result), 64'h7F800000);
    do_op(32'h00800000, 32'h80800000);  // R12
    chk(unf_flag && result == 32'h80000000, "R12", "underflow", 64'(result), 64'h80000000);
    do_op(32'h00000000, 32'hFF800000);  // R7
    chk(inv_flag && result == 32'h7FC00000, "R7", "zero*inf", 64'(result), 64'h7FC00000);
    do_op(32'h7F800000, 32'h80000000);  // R7 swapped
    do_op(32'h7F800001, 32'h3F800000);  // R8
    chk(!inv_flag && result == 32'h7FC00000, "R8", "nan", 64'(result), 64'h7FC00000);
    do_op(32'hFF800000, 32'hC0000000);  // R10
    chk(result == 32'h7F800000, "R10", "-inf*-2", 64'(result), 64'h7F800000);
    do_op(32'h00000001, 32'h3F800000);  // R9 subnormal flushed
    chk(result == 32'h00000000 && !unf_flag, "R9", "subnormal", 64'(result), 64'd0);
    do_op(32'h80000000, 32'h3F800000);  // R9 signed zero
    chk(result == 32'h80000000, "R9", "-0*1", 64'(result), 64'h80000000);

    // R2: second start during an operation is ignored
    @(negedge clk);
    op_a = 32'h40000000; op_b = 32'h40400000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nd = 0;
    for (int k = 0; k < 40; k++) begin
      if (done) begin
        nd++;
        chk(result == 32'h40C00000, "R2", "first op result", 64'(result), 64'h40C00000);
      end
      @(negedge clk);
    end
    chk(nd == 1, "R2", "done count", 64'(nd), 64'd1);

    for (int k = 0; k < 400; k++) begin
      x = $urandom;
      y = $urandom;
      if (k % 4 != 0) begin
        x[30:23] = 8'(90 + ($urandom % 76));
        y[30:23] = 8'(90 + ($urandom % 76));
      end
      do_op(x, y);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule